// File: doc/BRIEF.md
# Smart Card Activation Sequencer

This block brings a contact smart card into use after a host lowers an active-low activation command. It turns on the card supply and holds it for a supply-validity window counted in ticks of an internal oscillator. At the end of that window it samples a supply-good indication. If the supply is bad, it drops the supply and raises a fault. If the supply is good, it moves the card I/O lines into receive mode after a short delay. After a further short delay it starts the card clock.

Once the clock runs, the card reset is held low for a long count of card clock ticks. After that count the card reset becomes a live copy of the host's reset input. The host may raise its reset early, but the card reset stays low until the count ends. If the host raises the command again, activation is abandoned and every card output drops. All timing comes from single-cycle enable ticks in one system clock domain.

Top module: `card_act_seq`

## Requirements
- R1: After reset, and whenever the block is idle, supply enable, I/O receive, clock enable and card reset are 0, and the active-low fault flag is 1.
- R2: A high-to-low change of `cmd_n`, sampled at a clock edge while the block is idle or faulted, sets `vcc_en` to 1 from that edge on.
- R3: The supply phase lasts `SUPPLY_TICKS` oscillator ticks. `vcc_good` is sampled on the edge of the last tick. If it is 0, `vcc_en` falls to 0 and `fault_n` falls to 0 at that edge.
- R4: With a good supply, `io_rx` rises `RX_TICKS` oscillator ticks after the supply phase ends.
- R5: `cclk_en` rises `CLK_TICKS` oscillator ticks after `io_rx` rises.
- R6: `card_rst` stays 0 until `RST_HOLD_CLKS` card clock ticks have been counted after `cclk_en` rises, even while `host_rst` is 1. Cycles without a card clock tick do not advance this count.
- R7: After the hold count, `card_rst` equals `host_rst` combinationally, or one cycle later when `RST_REGISTERED` is 1.
- R8: `cmd_n` at 1 on any edge during activation returns the block to idle, and all card outputs are 0 after that edge.
- R9: Once `fault_n` is 0, it stays 0 until a new falling edge of `cmd_n`. That falling edge clears the fault and restarts the activation.
- R10: The outputs are nested in order: `cclk_en` high implies `io_rx` and `vcc_en` high, and `card_rst` high implies `cclk_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_n | input | 1 | Active-low activation command |
| host_rst | input | 1 | Host reset request to be passed to the card |
| vcc_good | input | 1 | Card supply valid indication |
| osc_tick | input | 1 | Single-cycle internal oscillator tick |
| cclk_tick | input | 1 | Single-cycle card clock tick |
| vcc_en | output | 1 | Card supply enable |
| io_rx | output | 1 | I/O lines (main and two auxiliary) in receive mode |
| cclk_en | output | 1 | Card clock enable |
| card_rst | output | 1 | Reset driven to the card |
| fault_n | output | 1 | Active-low supply fault flag |

## Verification
The hardest state to reach is a hold phase whose count stalls. Here the card clock is enabled and the host reset is already high, but no card clock ticks arrive. To reach it, the stimulus lets activation reach clock start with the card clock tick held low. It then runs many cycles and confirms that the card reset stays low. Only after that are the ticks released and the exact edge of release counted. A fault that must survive a raised and later lowered command is reached by withholding supply-good through the supply window.

// File: rtl/card_act_pkg.sv
package card_act_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_SUPPLY  = 3'd1,
      ST_RXWAIT  = 3'd2,
      ST_CLKWAIT = 3'd3,
      ST_HOLD    = 3'd4,
      ST_ACTIVE  = 3'd5,
      ST_FAULT   = 3'd6
   } act_state_t;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/card_act_timer.sv
module card_act_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   input  logic [CW-1:0] target,
   output logic          expire
);
   logic [CW-1:0] cnt_q;

   assign expire = tick && (cnt_q == target - CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= expire ? '0 : cnt_q + CW'(1);
   end
endmodule

// File: rtl/card_act_fsm.sv
module card_act_fsm
   import card_act_pkg::*;
#(
   parameter int CW            = 16,
   parameter int SUPPLY_TICKS  = 765,
   parameter int RX_TICKS      = 3,
   parameter int CLK_TICKS     = 1,
   parameter int RST_HOLD_CLKS = 42000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_n,
   input  logic          vcc_good,
   input  logic          expire,
   output act_state_t    state,
   output logic          phase_clr,
   output logic          use_cclk,
   output logic [CW-1:0] target
);
   act_state_t st_q, st_d;
   logic       cmd_prev_q;
   logic       cmd_fall;

   assign cmd_fall = cmd_prev_q && !cmd_n;

   always_comb begin
      st_d = st_q;
      if (st_q == ST_IDLE || st_q == ST_FAULT) begin
         if (cmd_fall) st_d = ST_SUPPLY;
      end else if (cmd_n) begin
         st_d = ST_IDLE;
      end else begin
         unique case (st_q)
            ST_SUPPLY:  if (expire) st_d = vcc_good ? ST_RXWAIT : ST_FAULT;
            ST_RXWAIT:  if (expire) st_d = ST_CLKWAIT;
            ST_CLKWAIT: if (expire) st_d = ST_HOLD;
            ST_HOLD:    if (expire) st_d = ST_ACTIVE;
            default:    st_d = st_q;
         endcase
      end
   end

   always_comb begin
      unique case (st_q)
         ST_SUPPLY:  target = CW'(SUPPLY_TICKS);
         ST_RXWAIT:  target = CW'(RX_TICKS);
         ST_CLKWAIT: target = CW'(CLK_TICKS);
         ST_HOLD:    target = CW'(RST_HOLD_CLKS);
         default:    target = '1;
      endcase
   end

   assign use_cclk  = (st_q == ST_HOLD);
   assign phase_clr = (st_d != st_q);
   assign state     = st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         cmd_prev_q <= 1'b1;
      end else begin
         st_q       <= st_d;
         cmd_prev_q <= cmd_n;
      end
   end
endmodule

// File: rtl/card_act_seq.sv
module card_act_seq
   import card_act_pkg::*;
#(
   parameter int SUPPLY_TICKS   = 765,
   parameter int RX_TICKS       = 3,
   parameter int CLK_TICKS      = 1,
   parameter int RST_HOLD_CLKS  = 42000,
   parameter bit RST_REGISTERED = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_n,
   input  logic host_rst,
   input  logic vcc_good,
   input  logic osc_tick,
   input  logic cclk_tick,
   output logic vcc_en,
   output logic io_rx,
   output logic cclk_en,
   output logic card_rst,
   output logic fault_n
);
   localparam int MAX_CNT = max4(SUPPLY_TICKS, RX_TICKS, CLK_TICKS, RST_HOLD_CLKS);
   localparam int CW      = $clog2(MAX_CNT + 1);

   if (SUPPLY_TICKS < 1 || RX_TICKS < 1 || CLK_TICKS < 1)
      $error("card_act_seq: phase tick counts must be at least 1");
   if (RST_HOLD_CLKS < 2)
      $error("card_act_seq: RST_HOLD_CLKS must be at least 2");

   act_state_t    state;
   logic          phase_clr, use_cclk, expire;
   logic [CW-1:0] target;

   card_act_fsm #(
      .CW(CW), .SUPPLY_TICKS(SUPPLY_TICKS), .RX_TICKS(RX_TICKS),
      .CLK_TICKS(CLK_TICKS), .RST_HOLD_CLKS(RST_HOLD_CLKS)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .cmd_n(cmd_n), .vcc_good(vcc_good),
      .expire(expire), .state(state), .phase_clr(phase_clr),
      .use_cclk(use_cclk), .target(target)
   );

   card_act_timer #(.CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(phase_clr),
      .tick(use_cclk ? cclk_tick : osc_tick),
      .target(target), .expire(expire)
   );

   assign vcc_en  = (state == ST_SUPPLY) || (state == ST_RXWAIT) ||
                    (state == ST_CLKWAIT) || (state == ST_HOLD) || (state == ST_ACTIVE);
   assign io_rx   = (state == ST_CLKWAIT) || (state == ST_HOLD) || (state == ST_ACTIVE);
   assign cclk_en = (state == ST_HOLD) || (state == ST_ACTIVE);
   assign fault_n = (state != ST_FAULT);

   if (RST_REGISTERED) begin : g_rst_reg
      logic rst_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rst_q <= 1'b0;
         else        rst_q <= (state == ST_ACTIVE) && host_rst && !cmd_n;
      end
      assign card_rst = rst_q && (state == ST_ACTIVE);
   end else begin : g_rst_comb
      assign card_rst = (state == ST_ACTIVE) && host_rst;
   end
endmodule

// File: rtl/card_act_seq_chk.sv
module card_act_seq_chk #(
   parameter bit RST_REGISTERED = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic cmd_n,
   input logic host_rst,
   input logic vcc_good,
   input logic vcc_en,
   input logic io_rx,
   input logic cclk_en,
   input logic card_rst,
   input logic fault_n
);
   // R2
   supply_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vcc_en) |-> !$past(cmd_n));

   // R3
   fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault_n) |-> ($past(vcc_en) && !$past(vcc_good)));

   // R8
   abort_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmd_n) |-> (!vcc_en && !io_rx && !cclk_en && !card_rst));

   // R9
   fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault_n && cmd_n) |=> !fault_n);

   // R10
   clk_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cclk_en |-> (io_rx && vcc_en));

   // R10
   rst_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      card_rst |-> cclk_en);

   // R6
   rst_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cclk_en) |=> !card_rst);

   if (!RST_REGISTERED) begin : g_follow
      // R7
      rst_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
         card_rst |-> host_rst);
   end
endmodule

bind card_act_seq card_act_seq_chk #(.RST_REGISTERED(RST_REGISTERED)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_n(cmd_n), .host_rst(host_rst),
   .vcc_good(vcc_good), .vcc_en(vcc_en), .io_rx(io_rx), .cclk_en(cclk_en),
   .card_rst(card_rst), .fault_n(fault_n)
);

// File: tb/card_act_seq_test.sv
module card_act_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int S = 6;
   localparam int R = 3;
   localparam int C = 2;
   localparam int H = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_n = 1'b1, host_rst = 1'b0, vcc_good = 1'b1;
   logic osc_tick = 1'b1, cclk_tick = 1'b1;
   logic vcc_en, io_rx, cclk_en, card_rst, fault_n;

   int n_checks = 0;
   int n_fail   = 0;
   int pos      = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   card_act_seq #(
      .SUPPLY_TICKS(S), .RX_TICKS(R), .CLK_TICKS(C), .RST_HOLD_CLKS(H)
   ) uut (
      .clk(clk), .rst_n(rst_n), .cmd_n(cmd_n), .host_rst(host_rst),
      .vcc_good(vcc_good), .osc_tick(osc_tick), .cclk_tick(cclk_tick),
      .vcc_en(vcc_en), .io_rx(io_rx), .cclk_en(cclk_en),
      .card_rst(card_rst), .fault_n(fault_n)
   );

   task automatic check(input string req, input string what,
                        input logic actual, input logic expected);
      n_checks++;
      if (actual !== expected) begin
         n_fail++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, actual, expected);
      end
   endtask

   task automatic check_off(input string req);
      check(req, "vcc_en", vcc_en, 1'b0);
      check(req, "io_rx", io_rx, 1'b0);
      check(req, "cclk_en", cclk_en, 1'b0);
      check(req, "card_rst", card_rst, 1'b0);
   endtask

   // advance to the point where `total` edges have passed since cmd_n fell
   task automatic goto(input int total);
      while (pos < total) begin
         @(posedge clk);
         pos++;
      end
      @(negedge clk);
   endtask

   task automatic start_act();
      @(negedge clk);
      cmd_n = 1'b0;
      pos = 0;
   endtask

   task automatic stop_act();
      @(negedge clk);
      cmd_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check_off("R1");
      check("R1", "fault_n", fault_n, 1'b1);
   endtask

   task automatic t_normal();
      host_rst = 1'b1;
      start_act();
      goto(1);
      check("R2", "vcc_en", vcc_en, 1'b1);
      goto(S);
      check("R3", "vcc_en in window", vcc_en, 1'b1);
      check("R3", "fault_n in window", fault_n, 1'b1);
      goto(S + R);
      check("R4", "io_rx early", io_rx, 1'b0);
      goto(S + R + 1);
      check("R4", "io_rx", io_rx, 1'b1);
      goto(S + R + C);
      check("R5", "cclk_en early", cclk_en, 1'b0);
      goto(S + R + C + 1);
      check("R5", "cclk_en", cclk_en, 1'b1);
      goto(S + R + C + H);
      check("R6", "card_rst held", card_rst, 1'b0);
      goto(S + R + C + H + 1);
      check("R7", "card_rst released", card_rst, 1'b1);
      host_rst = 1'b0;
      #1;
      check("R7", "card_rst follows low", card_rst, 1'b0);
      host_rst = 1'b1;
      #1;
      check("R7", "card_rst follows high", card_rst, 1'b1);
      stop_act();
      check_off("R8");
      host_rst = 1'b0;
   endtask

   task automatic t_fault();
      vcc_good = 1'b0;
      start_act();
      goto(S);
      check("R3", "vcc_en before check", vcc_en, 1'b1);
      check("R3", "fault_n before check", fault_n, 1'b1);
      goto(S + 1);
      check("R3", "vcc_en after bad supply", vcc_en, 1'b0);
      check("R3", "fault_n after bad supply", fault_n, 1'b0);
      cmd_n = 1'b1;
      vcc_good = 1'b1;
      goto(S + 6);
      check("R9", "fault_n kept", fault_n, 1'b0);
      check_off("R9");
      start_act();
      goto(1);
      check("R9", "fault_n cleared", fault_n, 1'b1);
      check("R9", "restart vcc_en", vcc_en, 1'b1);
      stop_act();
      check("R1", "fault_n idle", fault_n, 1'b1);
   endtask

   task automatic t_abort();
      host_rst = 1'b1;
      start_act();
      goto(S + R + C + 4);
      check("R8", "in hold cclk_en", cclk_en, 1'b1);
      stop_act();
      check_off("R8");
      check("R8", "fault_n", fault_n, 1'b1);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_off("R1");
      host_rst = 1'b0;
   endtask

   task automatic t_gate();
      host_rst = 1'b1;
      cclk_tick = 1'b0;
      start_act();
      goto(S + R + C + 1);
      check("R6", "cclk_en", cclk_en, 1'b1);
      goto(S + R + C + 1 + 60);
      check("R6", "card_rst without ticks", card_rst, 1'b0);
      cclk_tick = 1'b1;
      pos = 0;
      goto(H - 1);
      check("R6", "card_rst one tick short", card_rst, 1'b0);
      goto(H);
      check("R7", "card_rst after count", card_rst, 1'b1);
      check("R10", "order io_rx", io_rx, 1'b1);
      stop_act();
      check_off("R8");
      host_rst = 1'b0;
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      report();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_normal();
      t_fault();
      t_abort();
      t_gate();
      report();
   end
endmodule